// File: doc/BRIEF.md
# Memory-Mapped Watchdog Timer

This peripheral guards a system against software that has stopped making progress. It exposes two 32-bit words. The control/status word at byte offset 0 starts and stops the timer, selects what happens on expiry and reports whether the last restart came from the watchdog. The reload word at byte offset 4 holds a timeout in whole seconds. Once running, a prescaler divides the core clock down to a one-second tick and a counter steps down from the reload value. Software keeps the system alive by writing the trigger bit before the count runs out, normally every half second or so.

If the count reaches zero while running, the block raises either a system-reset request or a power-off request for exactly one clock. It then stops and sets a sticky fired flag. That flag lives in a flop fed only by the power-on reset, so it survives the system reset that the request causes. Boot software can read the flag to learn why the machine restarted.

Top module: `wdog_mmio`

## Requirements
- R1: After power-on reset the control word (offset 0) reads 0x08 (stopped, with the disabled bit 3 set), the reload word (offset 4) reads 60, and neither request output is high.
- R2: Writing the control word with bit 0 (run) going from 0 to 1 loads the counter from the reload value and clears the prescaler. With CLK_HZ cycles per second and reload N, the request output rises exactly N*CLK_HZ clock edges after that write edge.
- R3: Writing 1 to control bit 7 (trigger) reloads the counter and clears the prescaler. Triggering at intervals shorter than the timeout keeps any request from firing, and bit 7 always reads back as 0.
- R4: Control bit 2 picks the expiry action: 0 drives `sys_rst_req`, 1 drives `pwr_off_req`. The two requests are never high together.
- R5: Control bit 1 (fired) is set on expiry. It survives an assertion of `rst_n`, is cleared by `por_n`, and is cleared by writing 1 to bit 1.
- R6: Writing run=0 halts the countdown, and no request is raised while the timer is stopped.
- R7: A write to the reload word while running does not change the countdown in progress; the new value is used from the next trigger.
- R8: The reload word keeps only its low 10 bits (so 0x7FF reads back 0x3FF), and a stored value of 0 counts down as 1 second.
- R9: On expiry the request is high for one clock, the run bit clears, and the control word then shows the disabled bit set.
- R10: Writes to byte offsets other than 0 and 4 change no register and start nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, CLK_HZ cycles per second |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears everything |
| rst_n | input | 1 | System reset, asynchronous, active low; clears all but the fired flag |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 3 | Byte offset within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word selected by `addr` |
| sys_rst_req | output | 1 | One-cycle system-reset request on expiry |
| pwr_off_req | output | 1 | One-cycle power-off request on expiry |

## Verification
The bench targets expiry timing to the exact edge. If the prescaler were not cleared on start or trigger, or counted one cycle too many per second, the request would arrive early or late and the per-clock comparison would flag it. It exercises a reload write while running: a design applying it immediately would expire during the window where none is allowed. It also checks that the fired flag survives the system reset but not the power-on reset, that a zero reload behaves as one second, and that writes to unused offsets do nothing. A design failing any of these would show a stray, missing or misrouted request, or a wrong readback.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned CNT_W      = 10;
    localparam int unsigned ADDR_W     = 3;
    localparam int unsigned DATA_W     = 32;
    localparam logic [ADDR_W-1:0] OFS_CTL = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_CNT = 3'd4;
    localparam int unsigned B_RUN   = 0;
    localparam int unsigned B_FIRED = 1;
    localparam int unsigned B_PWR   = 2;
    localparam int unsigned B_OFF   = 3;
    localparam int unsigned B_TRIG  = 7;

    typedef struct packed {
        logic             run;
        logic             act_pwr;
        logic [CNT_W-1:0] reload;
        logic             srst;
        logic             poff;
        logic             fired;
    } wd_state_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int unsigned PW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
    localparam logic [PW-1:0] LIMIT = PW'(CLK_HZ - 1);

    logic [PW-1:0] pre_d, pre_q;

    assign tick = en && (pre_q == LIMIT);

    always_comb begin
        pre_d = pre_q;
        if (clr) begin
            pre_d = '0;
        end else if (tick) begin
            pre_d = '0;
        end else if (en) begin
            pre_d = pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expire,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] start_val;

    // a zero reload still gives one full second
    assign start_val = (load_val == '0) ? W'(1) : load_val;
    assign expire    = tick && (cnt_q == W'(1));
    assign count     = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = start_val;
        end else if (tick) begin
            cnt_d = (cnt_q <= W'(1)) ? '0 : cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wdog_mmio.sv
module wdog_mmio
    import wdog_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 100_000_000,
    parameter int unsigned RELOAD_RST = 60
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              sys_rst_req,
    output logic              pwr_off_req
);
    localparam logic [CNT_W-1:0] RST_RELOAD = CNT_W'(RELOAD_RST);

    wd_state_t st_d, st_q;
    logic      fired_q;
    logic      core_rst_n;
    logic      wr_ctl, wr_cnt;
    logic      load;
    logic      tick;
    logic      expire;
    logic [CNT_W-1:0] cnt_w;

    assign core_rst_n = rst_n & por_n;
    assign wr_ctl     = wr_en && (addr == OFS_CTL);
    assign wr_cnt     = wr_en && (addr == OFS_CNT);
    assign load       = wr_ctl && (wdata[B_TRIG] || (wdata[B_RUN] && !st_q.run));

    wdog_prescaler #(.CLK_HZ(CLK_HZ)) u_pre (
        .clk   (clk),
        .rst_n (core_rst_n),
        .clr   (load),
        .en    (st_q.run && !load),
        .tick  (tick)
    );

    wdog_countdown #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (core_rst_n),
        .load     (load),
        .load_val (st_q.reload),
        .tick     (tick),
        .expire   (expire),
        .count    (cnt_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.fired = fired_q;
        st_d.srst  = 1'b0;
        st_d.poff  = 1'b0;
        if (wr_ctl) begin
            st_d.run     = wdata[B_RUN];
            st_d.act_pwr = wdata[B_PWR];
            if (wdata[B_FIRED]) st_d.fired = 1'b0;
        end
        if (wr_cnt) begin
            st_d.reload = wdata[CNT_W-1:0];
        end
        if (expire) begin
            st_d.run   = 1'b0;
            st_d.fired = 1'b1;
            st_d.srst  = !st_q.act_pwr;
            st_d.poff  = st_q.act_pwr;
        end
    end

    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            st_q.run     <= 1'b0;
            st_q.act_pwr <= 1'b0;
            st_q.reload  <= RST_RELOAD;
            st_q.srst    <= 1'b0;
            st_q.poff    <= 1'b0;
            st_q.fired   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // sticky flag: only the power-on reset clears it
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) fired_q <= 1'b0;
        else        fired_q <= st_d.fired;
    end

    always_comb begin
        rdata = '0;
        if (addr == OFS_CTL) begin
            rdata[B_RUN]   = st_q.run;
            rdata[B_FIRED] = fired_q;
            rdata[B_PWR]   = st_q.act_pwr;
            rdata[B_OFF]   = !st_q.run;
        end else if (addr == OFS_CNT) begin
            rdata[CNT_W-1:0] = st_q.reload;
        end
    end

    assign sys_rst_req = st_q.srst;
    assign pwr_off_req = st_q.poff;
endmodule

// File: rtl/wdog_mmio_chk.sv
module wdog_mmio_chk #(
    parameter int unsigned CW = 10
) (
    input logic          clk,
    input logic          por_n,
    input logic          rst_n,
    input logic          wr_en,
    input logic          sys_rst_req,
    input logic          pwr_off_req,
    input logic          run,
    input logic          fired,
    input logic [CW-1:0] count
);
    p_excl_req_r4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !(sys_rst_req && pwr_off_req));

    p_srst_pulse_r9: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        sys_rst_req |=> !sys_rst_req);

    p_poff_pulse_r9: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        pwr_off_req |=> !pwr_off_req);

    p_stop_on_fire_r9: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (sys_rst_req || pwr_off_req) |-> !run);

    p_fired_set_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (sys_rst_req || pwr_off_req) |-> fired);

    p_fire_needs_run_r2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (sys_rst_req || pwr_off_req) |-> $past(run));

    p_frozen_when_stopped_r6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (!run && !wr_en) |=> $stable(count));
endmodule

bind wdog_mmio wdog_mmio_chk #(.CW(wdog_pkg::CNT_W)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .sys_rst_req (sys_rst_req),
    .pwr_off_req (pwr_off_req),
    .run         (st_q.run),
    .fired       (fired_q),
    .count       (cnt_w)
);

// File: tb/test_wdog_mmio.sv
module test_wdog_mmio;
    localparam int P = 10;

    logic        clk = 1'b0;
    logic        por_n, rst_n, wr_en;
    logic [2:0]  addr;
    logic [31:0] wdata, rdata;
    logic        sys_rst_req, pwr_off_req;

    int checks = 0, fails = 0;
    int n_srst = 0, n_pwr = 0;
    int cyc = 0;

    // behavioural reference state
    int m_run = 0, m_act = 0, m_fired = 0, m_reload = 60, m_left = 0;
    int m_s = 0, m_p = 0;

    always #5 clk = ~clk;

    wdog_mmio #(.CLK_HZ(P), .RELOAD_RST(60)) i_wdog_mmio (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sys_rst_req(sys_rst_req), .pwr_off_req(pwr_off_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // reference model, updated on each edge from the inputs present at it
    always @(posedge clk) begin
        int old_run, ld, n;
        old_run = m_run; ld = 0; m_s = 0; m_p = 0;
        if (!por_n) begin
            m_run = 0; m_act = 0; m_fired = 0; m_reload = 60; m_left = 0;
        end else if (!rst_n) begin
            m_run = 0; m_act = 0; m_reload = 60; m_left = 0;
        end else begin
            if (wr_en && addr == 3'd0) begin
                ld = (wdata[7] || (wdata[0] && old_run == 0)) ? 1 : 0;
                if (wdata[1]) m_fired = 0;
                m_run = wdata[0]; m_act = wdata[2];
                if (ld != 0) begin
                    n = (m_reload == 0) ? 1 : m_reload;
                    m_left = n * P;
                end
            end else if (wr_en && addr == 3'd4) begin
                m_reload = wdata & 32'h3FF;
            end
            if (ld == 0 && old_run != 0 && m_left > 0) begin
                m_left--;
                if (m_left == 0) begin
                    m_run = 0; m_fired = 1;
                    if (m_act != 0) m_p = 1; else m_s = 1;
                end
            end
        end
    end

    always @(posedge clk) begin
        logic [31:0] exp_rd;
        #2;
        cyc++;
        if (sys_rst_req) n_srst++;
        if (pwr_off_req) n_pwr++;
        if (por_n && rst_n) begin
            check("R2 model sys_rst_req", 32'(sys_rst_req), 32'(m_s));
            check("R4 model pwr_off_req", 32'(pwr_off_req), 32'(m_p));
            if (addr == 3'd0)
                exp_rd = 32'(m_run) | (32'(m_fired) << 1) | (32'(m_act) << 2) | (32'(m_run == 0) << 3);
            else if (addr == 3'd4)
                exp_rd = 32'(m_reload);
            else
                exp_rd = 0;
            check("R3 model readback", rdata, exp_rd);
        end
    end

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0; addr = 3'd0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_cnt();
        n_srst = 0; n_pwr = 0;
    endtask

    initial begin
        logic [31:0] v;
        por_n = 1'b0; rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        idle(3);
        por_n = 1'b1; rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd(3'd0, v); check("R1 ctl after por", v, 32'h08);
        rd(3'd4, v); check("R1 reload after por", v, 32'd60);
        check("R1 no request", 32'(sys_rst_req | pwr_off_req), 0);

        // R2/R9: start with 3 s, let it expire
        wr(3'd4, 3); clr_cnt();
        wr(3'd0, 32'h01);
        idle(35);
        check("R2 one reset request", 32'(n_srst), 1);
        check("R4 no poweroff when bit2=0", 32'(n_pwr), 0);
        rd(3'd0, v); check("R9 stopped with fired set", v, 32'h0A);

        // R5 write-one clear
        wr(3'd0, 32'h02);
        rd(3'd0, v); check("R5 fired cleared by W1", v, 32'h08);

        // R3 keep-alive triggers
        clr_cnt();
        wr(3'd0, 32'h01);
        for (int i = 0; i < 10; i++) begin
            idle(18);
            wr(3'd0, 32'h81);
        end
        check("R3 no request while triggered", 32'(n_srst + n_pwr), 0);
        rd(3'd0, v); check("R3 trigger bit reads 0", v, 32'h01);

        // R7 reload write while running waits for a trigger
        wr(3'd4, 1);
        idle(15);
        check("R7 old countdown still running", 32'(n_srst + n_pwr), 0);
        rd(3'd4, v); check("R7 reload reads new value", v, 32'd1);
        wr(3'd0, 32'h81);
        idle(12);
        check("R7 new value used after trigger", 32'(n_srst), 1);

        // R4 power-off action
        wr(3'd0, 32'h02); clr_cnt();
        wr(3'd0, 32'h05);
        idle(12);
        check("R4 poweroff request", 32'(n_pwr), 1);
        check("R4 no reset request", 32'(n_srst), 0);
        rd(3'd0, v); check("R4 ctl after poweroff", v, 32'h0E);

        // R5 survival across system reset, cleared by por
        @(negedge clk); rst_n = 1'b0; idle(2); rst_n = 1'b1;
        rd(3'd0, v); check("R5 fired survives rst_n", v, 32'h0A);
        rd(3'd4, v); check("R5 reload reset by rst_n", v, 32'd60);
        @(negedge clk); por_n = 1'b0; idle(2); por_n = 1'b1;
        rd(3'd0, v); check("R5 fired cleared by por_n", v, 32'h08);

        // R6 stop halts countdown
        wr(3'd4, 2); clr_cnt();
        wr(3'd0, 32'h01);
        idle(5);
        wr(3'd0, 32'h00);
        idle(100);
        check("R6 no request while stopped", 32'(n_srst + n_pwr), 0);
        rd(3'd0, v); check("R6 ctl stopped", v, 32'h08);

        // R8 zero reload and width
        wr(3'd4, 0);
        rd(3'd4, v); check("R8 zero reload reads 0", v, 0);
        clr_cnt();
        wr(3'd0, 32'h01);
        idle(12);
        check("R8 zero counts as one second", 32'(n_srst), 1);
        wr(3'd4, 32'h7FF);
        rd(3'd4, v); check("R8 reload truncated to 10 bits", v, 32'h3FF);

        // R10 unused offsets
        wr(3'd0, 32'h02); clr_cnt();
        wr(3'd2, 32'h81);
        wr(3'd6, 32'h5);
        idle(5);
        rd(3'd0, v); check("R10 ctl untouched", v, 32'h08);
        rd(3'd4, v); check("R10 reload untouched", v, 32'h3FF);
        check("R10 nothing started", 32'(n_srst + n_pwr), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule